// File: doc/BRIEF.md
# Presettable Timer Channel with Read Latches

This block is a single, self-contained timer channel. It holds a 16-bit down counter that software loads with a count and that steps down by one on each clock where the count-enable input is high. A per-channel control word sets how count bytes are written and read: low byte only, high byte only, or low byte followed by high byte. The output starts low and rises when the counter reaches terminal count. Gate control and the other waveform modes are not part of this channel.

Software never reads the live counter directly. It reads a pair of byte latches. These latches track the counter one clock behind. A counter-latch command freezes them so that a multi-byte read is coherent. A separate status-latch command captures one byte holding the output level, a null-count flag and the stored control bits. When a status snapshot is pending, the next read returns that snapshot before any count byte.

The bus interface in front of this channel decodes addresses and presents decoded strobes. The control-word bits used here are bits 5:0. Bits 5:4 form the access field. Bits 3:0 are only stored and reported back.

Top module: `timer_channel`

## Requirements
- R1: After reset the output is low, the null-count flag is clear, no latch is pending, the counter and byte latches hold zero, the stored control bits are zero, and the next count read selects the low byte. In this state a status snapshot reads 0x00.
- R2: A control-word write whose access field (bits 5:4) is nonzero stores bits 5:0 and drives the output low on the next clock. It also restarts both the write byte sequence and the read byte sequence, drops any frozen count latch and any pending status snapshot, and stops counting until a new count is transferred.
- R3: The access field sets the count write format. 01 loads the low byte and clears the high byte. 10 loads the high byte and clears the low byte. 11 takes the low byte first and the high byte second, and the load completes only on the second byte. Count writes are ignored while the field is 00, which is the case after reset.
- R4: On the clock after a count load completes, the counter takes the new count and the null-count flag clears. A loaded count of zero gives 65536 decrements before terminal count, because the counter wraps from 0x0000 to 0xFFFF.
- R5: Once a count has been transferred, the counter decrements by one on every clock where the count-enable input is high, and it holds its value otherwise. Between a control-word write and the next transfer it holds even when enabled.
- R6: The output rises on the clock where the counter steps from 1 to 0. It stays high, including through the wrap, until the next control-word write or completed count load, either of which drives it low.
- R7: While not frozen, the byte latches load the counter value on every clock, so a read shows the count as it stood one clock earlier.
- R8: A control-word write with access field 00 is a counter-latch command. It captures the counter into the byte latches and freezes them. A further latch command while they are frozen is ignored. The freeze ends when the last byte of the format is read: the single byte in formats 01 and 10, the high byte in format 11.
- R9: Count reads return the low byte in format 01 and the high byte in format 10. In format 11 they alternate, low byte first.
- R10: A status-latch command captures {output, null-count, control bits 5:0}, with the output in bit 7 and the null-count flag in bit 6. A repeated status-latch command while one is pending is ignored. While a snapshot is pending, the next read returns it and does not advance the count byte sequence.
- R11: The null-count flag sets on every control-word write with a nonzero access field and on every completed count load. It stays set until the next transfer into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_wr | input | 1 | Control-word write strobe (access field 00 means counter-latch command) |
| cw_data | input | 6 | Control-word bits 5:0 |
| st_latch | input | 1 | Status-latch command strobe |
| cnt_wr | input | 1 | Count byte write strobe |
| cnt_data | input | 8 | Count byte |
| rd | input | 1 | Read strobe; advances the read sequence at the clock edge |
| rd_data | output | 8 | Byte presented for the current read |
| cnt_en | input | 1 | Count enable; one decrement per enabled clock |
| out_o | output | 1 | Channel output, high after terminal count |

## Verification
The hardest situation to reach is a status snapshot and a frozen count latch pending together. The read order then depends on which one is pending, and a second status command must have no visible effect. The stimulus reaches this by issuing a status latch and then a counter latch, running the counter so that live and latched values differ, and checking that status, low byte and high byte come back in that order. A second snapshot is then taken across a fresh count load, so that an ignored command would show up as a changed null-count bit. The zero-count case is driven through all 65536 decrements to pin the wrap point.

// File: rtl/timer_pkg.sv
package timer_pkg;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'b00,
      ACC_LSB   = 2'b01,
      ACC_MSB   = 2'b10,
      ACC_WORD  = 2'b11
   } acc_fmt_e;

   // Position of the two-bit access field inside the control bits
   localparam int ACC_POS = 4;

   function automatic acc_fmt_e acc_of(input logic [5:0] cw);
      return acc_fmt_e'(cw[ACC_POS +: 2]);
   endfunction

endpackage

// File: rtl/tch_count_reg.sv
module tch_count_reg
   import timer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  acc_fmt_e          fmt,
   input  logic              cnt_wr,
   input  logic [BYTE_W-1:0] cnt_data,
   output logic [CNT_W-1:0]  cr_q,
   output logic              load_pend_q,
   output logic              load_done,
   output logic              null_q
);

   localparam int HI_LO = CNT_W - BYTE_W;

   logic wr_hi_q;
   logic wr_ok;

   assign wr_ok = cnt_wr && (fmt != ACC_LATCH);

   always_comb begin
      load_done = 1'b0;
      if (wr_ok) begin
         unique case (fmt)
            ACC_LSB, ACC_MSB: load_done = 1'b1;
            ACC_WORD:         load_done = wr_hi_q;
            default:          load_done = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cr_q        <= '0;
         wr_hi_q     <= 1'b0;
         load_pend_q <= 1'b0;
         null_q      <= 1'b0;
      end else if (cfg_wr) begin
         wr_hi_q     <= 1'b0;
         load_pend_q <= 1'b0;
         null_q      <= 1'b1;
      end else begin
         if (wr_ok) begin
            unique case (fmt)
               ACC_LSB: cr_q <= {{HI_LO{1'b0}}, cnt_data};
               ACC_MSB: cr_q <= {cnt_data, {HI_LO{1'b0}}};
               ACC_WORD: begin
                  if (wr_hi_q) cr_q[CNT_W-1 -: BYTE_W] <= cnt_data;
                  else         cr_q[BYTE_W-1:0]       <= cnt_data;
                  wr_hi_q <= ~wr_hi_q;
               end
               default: cr_q <= cr_q;
            endcase
         end
         if (load_done) begin
            load_pend_q <= 1'b1;
            null_q      <= 1'b1;
         end else if (load_pend_q) begin
            load_pend_q <= 1'b0;
            null_q      <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/tch_count_elem.sv
module tch_count_elem #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             load_pend,
   input  logic             load_done,
   input  logic [CNT_W-1:0] cr,
   input  logic             cnt_en,
   output logic [CNT_W-1:0] ce_q,
   output logic             armed_q,
   output logic             out_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic dec;

   assign dec = cnt_en && armed_q && !load_pend && !cfg_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_q    <= '0;
         armed_q <= 1'b0;
         out_q   <= 1'b0;
      end else begin
         if (load_pend) begin
            ce_q    <= cr;
            armed_q <= 1'b1;
         end else if (dec) begin
            ce_q <= ce_q - ONE;
         end
         if (cfg_wr) armed_q <= 1'b0;

         if (cfg_wr || load_done)    out_q <= 1'b0;
         else if (dec && ce_q == ONE) out_q <= 1'b1;
      end
   end

endmodule

// File: rtl/tch_read_path.sv
module tch_read_path
   import timer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              latch_cmd,
   input  logic              st_cmd,
   input  logic              rd,
   input  acc_fmt_e          fmt,
   input  logic [CNT_W-1:0]  ce,
   input  logic [BYTE_W-1:0] status_in,
   output logic [CNT_W-1:0]  ol_q,
   output logic              frozen_q,
   output logic              st_pend_q,
   output logic [BYTE_W-1:0] rd_data
);

   localparam int NB = CNT_W / BYTE_W;

   logic [BYTE_W-1:0] st_q;
   logic              rd_hi_q;
   logic              rd_cnt;
   logic              last_byte;
   logic              sel_hi;
   logic [BYTE_W-1:0] lane [NB];

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign lane[i] = ol_q[i*BYTE_W +: BYTE_W];
   end

   assign rd_cnt    = rd && !st_pend_q;
   assign last_byte = (fmt != ACC_WORD) || rd_hi_q;
   assign sel_hi    = (fmt == ACC_MSB) || ((fmt == ACC_WORD) && rd_hi_q);
   assign rd_data   = st_pend_q ? st_q : lane[sel_hi ? NB-1 : 0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ol_q      <= '0;
         frozen_q  <= 1'b0;
         rd_hi_q   <= 1'b0;
      end else if (cfg_wr) begin
         ol_q      <= ce;
         frozen_q  <= 1'b0;
         rd_hi_q   <= 1'b0;
      end else begin
         if (!frozen_q) ol_q <= ce;
         if (latch_cmd && !frozen_q)       frozen_q <= 1'b1;
         else if (rd_cnt && last_byte)     frozen_q <= 1'b0;
         if (rd_cnt && fmt == ACC_WORD)    rd_hi_q  <= ~rd_hi_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= '0;
         st_pend_q <= 1'b0;
      end else if (cfg_wr) begin
         st_pend_q <= 1'b0;
      end else if (st_cmd && !st_pend_q) begin
         st_q      <= status_in;
         st_pend_q <= 1'b1;
      end else if (rd && st_pend_q) begin
         st_pend_q <= 1'b0;
      end
   end

endmodule

// File: rtl/timer_channel.sv
module timer_channel
   import timer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   parameter int CW_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cw_wr,
   input  logic [CW_W-1:0]   cw_data,
   input  logic              st_latch,
   input  logic              cnt_wr,
   input  logic [BYTE_W-1:0] cnt_data,
   input  logic              rd,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              cnt_en,
   output logic              out_o
);

   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("timer_channel: CNT_W must be two bytes wide");
   end
   if (BYTE_W != CW_W + 2) begin : g_bad_status
      $error("timer_channel: status byte needs CW_W + 2 bits");
   end
   if (CW_W != 6) begin : g_bad_cw
      $error("timer_channel: control field must be six bits");
   end

   logic [CW_W-1:0]   cw_q;
   acc_fmt_e          fmt;
   logic              cfg_wr;
   logic              latch_cmd;
   logic [CNT_W-1:0]  cr_q;
   logic              load_pend_q;
   logic              load_done;
   logic              null_q;
   logic [CNT_W-1:0]  ce_q;
   logic              armed_q;
   logic              out_q;
   logic [CNT_W-1:0]  ol_q;
   logic              frozen_q;
   logic              st_pend_q;
   logic [BYTE_W-1:0] status_in;

   assign fmt       = acc_of(cw_q);
   assign cfg_wr    = cw_wr && (acc_of(cw_data) != ACC_LATCH);
   assign latch_cmd = cw_wr && (acc_of(cw_data) == ACC_LATCH);
   assign status_in = {out_q, null_q, cw_q};
   assign out_o     = out_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cw_q <= '0;
      else if (cfg_wr) cw_q <= cw_data;
   end

   tch_count_reg #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (cfg_wr),
      .fmt         (fmt),
      .cnt_wr      (cnt_wr),
      .cnt_data    (cnt_data),
      .cr_q        (cr_q),
      .load_pend_q (load_pend_q),
      .load_done   (load_done),
      .null_q      (null_q)
   );

   tch_count_elem #(.CNT_W(CNT_W)) u_elem (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .load_pend (load_pend_q),
      .load_done (load_done),
      .cr        (cr_q),
      .cnt_en    (cnt_en),
      .ce_q      (ce_q),
      .armed_q   (armed_q),
      .out_q     (out_q)
   );

   tch_read_path #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .latch_cmd (latch_cmd),
      .st_cmd    (st_latch),
      .rd        (rd),
      .fmt       (fmt),
      .ce        (ce_q),
      .status_in (status_in),
      .ol_q      (ol_q),
      .frozen_q  (frozen_q),
      .st_pend_q (st_pend_q),
      .rd_data   (rd_data)
   );

endmodule

// File: rtl/timer_channel_chk.sv
module timer_channel_chk #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   parameter int CW_W   = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cw_wr,
   input logic [CW_W-1:0]   cw_data,
   input logic              cnt_wr,
   input logic              rd,
   input logic              cnt_en,
   input logic              out_o,
   input logic [BYTE_W-1:0] rd_data,
   input logic [CNT_W-1:0]  ce,
   input logic [CNT_W-1:0]  cr,
   input logic [CNT_W-1:0]  ol,
   input logic              load_pend,
   input logic              armed,
   input logic              null_flag,
   input logic              frozen,
   input logic              st_pend
);

   logic cfg;
   assign cfg = cw_wr && (cw_data[5:4] != 2'b00);

   assert_out_low_on_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg |=> !out_o);

   assert_transfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_pend && !cw_wr && !cnt_wr |=> (ce == $past(cr)) && !null_flag);

   assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
      armed && cnt_en && !load_pend && !cw_wr |=> ce == $past(ce) - 1'b1);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en && !load_pend |=> $stable(ce));

   assert_terminal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && cnt_en && !load_pend && !cw_wr && !cnt_wr && ce == CNT_W'(1) |=> out_o);

   assert_out_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_o && !cw_wr && !cnt_wr |=> out_o);

   assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !frozen |=> ol == $past(ce));

   assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frozen && !cw_wr && !rd |=> frozen && $stable(ol));

   assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      st_pend && !rd && !cw_wr |=> st_pend && $stable(rd_data));

   assert_null_on_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg |=> null_flag);

endmodule

bind timer_channel timer_channel_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .CW_W(CW_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cw_wr     (cw_wr),
   .cw_data   (cw_data),
   .cnt_wr    (cnt_wr),
   .rd        (rd),
   .cnt_en    (cnt_en),
   .out_o     (out_o),
   .rd_data   (rd_data),
   .ce        (ce_q),
   .cr        (cr_q),
   .ol        (ol_q),
   .load_pend (load_pend_q),
   .armed     (armed_q),
   .null_flag (null_q),
   .frozen    (frozen_q),
   .st_pend   (st_pend_q)
);

// File: tb/timer_channel_test.sv
module timer_channel_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cw_wr = 1'b0;
   logic [5:0] cw_data = '0;
   logic       st_latch = 1'b0;
   logic       cnt_wr = 1'b0;
   logic [7:0] cnt_data = '0;
   logic       rd = 1'b0;
   logic [7:0] rd_data;
   logic       cnt_en = 1'b0;
   logic       out_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   timer_channel uut (
      .clk(clk), .rst_n(rst_n), .cw_wr(cw_wr), .cw_data(cw_data),
      .st_latch(st_latch), .cnt_wr(cnt_wr), .cnt_data(cnt_data),
      .rd(rd), .rd_data(rd_data), .cnt_en(cnt_en), .out_o(out_o)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_cw(input logic [5:0] d);
      cw_wr = 1'b1; cw_data = d;
      @(negedge clk);
      cw_wr = 1'b0;
   endtask

   task automatic write_cnt(input logic [7:0] d);
      cnt_wr = 1'b1; cnt_data = d;
      @(negedge clk);
      cnt_wr = 1'b0;
   endtask

   task automatic latch_status();
      st_latch = 1'b1;
      @(negedge clk);
      st_latch = 1'b0;
   endtask

   task automatic read_byte(output logic [7:0] v);
      v = rd_data;
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic run(input int n);
      cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
   endtask

   task automatic expect_read(input string req, input logic [7:0] exp);
      logic [7:0] v;
      read_byte(v);
      check(req, {8'h00, v}, {8'h00, exp});
   endtask

   task automatic t_reset();
      check("R1 out", {15'b0, out_o}, 16'h0000);
      check("R1 read", {8'h00, rd_data}, 16'h0000);
      latch_status();
      expect_read("R1 status", 8'h00);
      write_cnt(8'h44);               // R3 ignored while field is 00
      idle(2);
      expect_read("R3 ignored write", 8'h00);
   endtask

   task automatic t_word_load();
      write_cw(6'h30);
      latch_status();
      expect_read("R11 null after cw / R2", 8'h70);
      write_cnt(8'h34);
      write_cnt(8'h12);
      idle(2);
      expect_read("R9 low first", 8'h34);
      expect_read("R3 word high", 8'h12);
      latch_status();
      expect_read("R4 null cleared", 8'h30);
      check("R2 out low", {15'b0, out_o}, 16'h0000);
   endtask

   task automatic t_decrement();
      run(5);
      idle(1);
      expect_read("R5 dec low", 8'h2F);
      expect_read("R7 dec high", 8'h12);
      idle(3);
      expect_read("R5 hold low", 8'h2F);
      expect_read("R5 hold high", 8'h12);
   endtask

   task automatic t_latch();
      write_cw(6'h00);
      run(10);
      expect_read("R8 frozen low", 8'h2F);
      expect_read("R8 frozen high", 8'h12);
      idle(1);
      expect_read("R8 released low", 8'h25);
      expect_read("R8 released high", 8'h12);
      write_cw(6'h00);
      run(4);
      write_cw(6'h00);               // ignored: already frozen
      run(4);
      expect_read("R8 second latch ignored low", 8'h25);
      expect_read("R8 second latch ignored high", 8'h12);
      idle(1);
      expect_read("R7 live low", 8'h1D);
      expect_read("R7 live high", 8'h12);
   endtask

   task automatic t_both_pending();
      latch_status();
      write_cw(6'h00);
      run(2);
      expect_read("R10 status first", 8'h30);
      expect_read("R10 then low", 8'h1D);
      expect_read("R10 then high", 8'h12);
      latch_status();
      write_cnt(8'h05);
      write_cnt(8'h00);
      latch_status();                 // ignored: one already pending
      expect_read("R10 repeat ignored", 8'h30);
      idle(1);
      latch_status();
      expect_read("R11 null clear after transfer", 8'h30);
      expect_read("R4 new count low", 8'h05);
      expect_read("R4 new count high", 8'h00);
   endtask

   task automatic t_terminal();
      run(4);
      check("R6 before tc", {15'b0, out_o}, 16'h0000);
      run(1);
      check("R6 at tc", {15'b0, out_o}, 16'h0001);
      run(1);
      check("R6 sticky through wrap", {15'b0, out_o}, 16'h0001);
      idle(1);
      expect_read("R4 wrap low", 8'hFF);
      expect_read("R4 wrap high", 8'hFF);
      write_cnt(8'h02);
      write_cnt(8'h00);
      check("R6 low on load", {15'b0, out_o}, 16'h0000);
      latch_status();
      expect_read("R11 null on load", 8'h70);
   endtask

   task automatic t_zero_lsb();
      write_cw(6'h10);
      write_cnt(8'h00);
      idle(2);
      expect_read("R9 lsb only", 8'h00);
      expect_read("R9 lsb repeat", 8'h00);
      run(1);
      idle(1);
      expect_read("R4 zero wraps", 8'hFF);
      run(65534);
      check("R4 65535 steps no tc", {15'b0, out_o}, 16'h0000);
      run(1);
      check("R4 tc after 65536", {15'b0, out_o}, 16'h0001);
   endtask

   task automatic t_msb_only();
      write_cw(6'h20);
      check("R2 out low on cw", {15'b0, out_o}, 16'h0000);
      run(3);
      idle(1);
      expect_read("R5 no count before load", 8'h00);
      write_cnt(8'h05);
      idle(2);
      expect_read("R3 msb load", 8'h05);
      expect_read("R9 msb repeat", 8'h05);
      run(1);
      idle(1);
      expect_read("R9 msb after dec", 8'h04);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_word_load();
      t_decrement();
      t_latch();
      t_both_pending();
      t_terminal();
      t_zero_lsb();
      t_msb_only();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule